// File: doc/BRIEF.md
# I2C Serial EEPROM Slave Controller

This block is the digital control side of a byte-addressable serial memory that answers as a slave on a two-wire I2C bus. It watches SCL and SDA through synchronisers running on the system clock, finds start and stop conditions, and moves bytes in and out with the ninth-clock acknowledge. It pulls SDA low only through an open-drain enable. Storage is a register array of 2^ADDR_W bytes (13 address bits give 8 KiB), plus a separate 32-byte identification page that can be locked for good.

A master selects the device with a select byte. It then sends a two-byte address and either writes one or more data bytes, or issues a repeated start and reads. A read can also start straight from the internal address pointer. Writes are stored as each byte is acknowledged. The stop that ends a write starts a programming period of PROG_CYCLES clocks, and the device stays silent to its select byte during that period. A write-control input protects all storage. The chip-enable inputs must be tied on the board; an unconnected one is to be tied low.

Top module: `i2c_eeprom_ctl`

## Requirements
- R1: The select byte is acknowledged only when bits 7..5 are 101, bits 3..1 equal chip_en and no programming period runs. Bit 4 picks the storage (0 array, 1 identification page), and bit 0 picks the direction (1 read). Any other select byte gets no acknowledge.
- R2: After a write select, the high and then the low address byte are acknowledged. The pointer takes the low ADDR_W bits of {high, low}, and a data byte is stored there.
- R3: Further data bytes in one write go to following addresses. Only the low PAGE_W (5) address bits advance, so the addresses wrap inside the 32-byte page.
- R4: A dummy write of an address followed by a repeated start and a read select returns the byte at that address.
- R5: A read with no address phase starts at the pointer. The pointer sits after the last byte written (wrapping inside the page) or after the last byte sent.
- R6: A read goes on with the next byte while the master acknowledges, crossing page boundaries and rolling over from the top address to 0. A master non-acknowledge ends it and releases SDA.
- R7: While wr_ctl is high, data bytes to either storage get no acknowledge and nothing is changed. The select and address bytes are still acknowledged.
- R8: A stop after at least one accepted data byte or lock command starts a programming period of PROG_CYCLES clocks. During it the select byte is not acknowledged; afterwards it is again.
- R9: The identification page is written and read like the array, using the low 5 pointer bits with wrap inside the page.
- R10: A write to the identification page with bit 2 of the high address byte set is a lock command. A data byte with bit 1 set is acknowledged and locks the page at the stop. Once locked, data bytes to the page and further lock commands get no acknowledge, the page keeps its contents, and the lock stays until reset. The array is not affected.
- R11: After reset, and after any stop, the block releases SDA (sda_oe low).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the bus |
| rst_n | input | 1 | Active-low reset |
| scl_in | input | 1 | Bus clock level |
| sda_in | input | 1 | Bus data level as seen on the wire |
| sda_oe | output | 1 | High pulls SDA low (open drain) |
| chip_en | input | 3 | Expected select bits 3..1 |
| wr_ctl | input | 1 | High blocks all writes |

## Verification
The bench builds the block with ADDR_W = 8, so the array has 256 bytes. Sequential reads reach the rollover from the top address in a few bytes, and random addresses often hit locations already written. PAGE_W stays at 5, so page wrapping is exercised at its real size. PROG_CYCLES = 400 keeps the busy window short enough to poll through quickly, yet longer than one select byte, so a refused select right after a write is observable.

// File: rtl/eeprom_pkg.sv
package eeprom_pkg;
  localparam int BYTE_W = 8;
  localparam logic [2:0] DEV_TYPE = 3'b101;
  localparam int LOCK_HI_BIT = 2;
  localparam int LOCK_DATA_BIT = 1;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_DEV,
    PH_ADRH,
    PH_ADRL,
    PH_WDATA,
    PH_RDATA,
    PH_IGNORE
  } phase_t;
endpackage

// File: rtl/i2c_bus_sense.sv
module i2c_bus_sense #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  logic [STAGES-1:0] scl_q, sda_q;
  logic scl_d, sda_d, scl_now;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scl_q <= '1;
      sda_q <= '1;
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_q <= {scl_q[STAGES-2:0], scl_in};
      sda_q <= {sda_q[STAGES-2:0], sda_in};
      scl_d <= scl_q[STAGES-1];
      sda_d <= sda_q[STAGES-1];
    end
  end

  assign scl_now  = scl_q[STAGES-1];
  assign sda_s    = sda_q[STAGES-1];
  assign scl_rise = scl_now && !scl_d;
  assign scl_fall = !scl_now && scl_d;
  // data edges while the clock stays high mark frame boundaries
  assign start_ev = scl_now && scl_d && sda_d && !sda_s;
  assign stop_ev  = scl_now && scl_d && !sda_d && sda_s;
endmodule

// File: rtl/prog_timer.sv
module prog_timer #(
  parameter int CYCLES = 5000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic kick,
  output logic busy
);
  localparam int CW = $clog2(CYCLES + 1);
  localparam logic [CW-1:0] LOAD = CW'(CYCLES);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) cnt <= '0;
    else if (kick) cnt <= LOAD;
    else if (cnt != '0) cnt <= cnt - 1'b1;
  end

  assign busy = (cnt != '0);
endmodule

// File: rtl/eeprom_store.sv
module eeprom_store #(
  parameter int ADDR_W = 11,
  parameter int PAGE_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              id_sel,
  input  logic              we,
  input  logic [7:0]        wdata,
  input  logic              lock_set,
  output logic [7:0]        rdata,
  output logic              locked
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int PAGE  = 1 << PAGE_W;

  logic [7:0] mem_q [DEPTH];
  logic [7:0] id_q  [PAGE];

  always_ff @(posedge clk) begin
    if (we && !id_sel) mem_q[addr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (we && id_sel) id_q[addr[PAGE_W-1:0]] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) locked <= 1'b0;
    else if (lock_set) locked <= 1'b1;
  end

  assign rdata = id_sel ? id_q[addr[PAGE_W-1:0]] : mem_q[addr];
endmodule

// File: rtl/i2c_eeprom_ctl.sv
module i2c_eeprom_ctl
  import eeprom_pkg::*;
#(
  parameter int ADDR_W      = 11,
  parameter int PAGE_W      = 5,
  parameter int PROG_CYCLES = 5000,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_in,
  input  logic       sda_in,
  output logic       sda_oe,
  input  logic [2:0] chip_en,
  input  logic       wr_ctl
);
  logic sda_s, scl_rise, scl_fall, start_ev, stop_ev;
  logic busy, locked, kick, lock_set;
  logic [7:0] rdata;

  phase_t phase;
  logic [3:0] bitn;
  logic ack_slot, acked, mack;
  logic [7:0] sr, tx, hi_q;
  logic id_sel, lock_arm, lock_pend, wrote;
  logic [ADDR_W-1:0] ptr, page_inc, rd_inc;
  logic rx_phase, byte_done, dev_hit, wr_ok, give_ack, st_we;

  i2c_bus_sense #(.STAGES(SYNC_STAGES)) u_sense (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
    .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_ev(start_ev), .stop_ev(stop_ev)
  );

  prog_timer #(.CYCLES(PROG_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .kick(kick), .busy(busy)
  );

  eeprom_store #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_store (
    .clk(clk), .rst_n(rst_n), .addr(ptr), .id_sel(id_sel), .we(st_we),
    .wdata(sr), .lock_set(lock_set), .rdata(rdata), .locked(locked)
  );

  assign kick     = stop_ev && (wrote || lock_pend);
  assign lock_set = stop_ev && lock_pend;
  assign page_inc = {ptr[ADDR_W-1:PAGE_W], ptr[PAGE_W-1:0] + 1'b1};
  assign rd_inc   = id_sel ? page_inc : ptr + 1'b1;

  always_comb begin
    rx_phase  = (phase == PH_DEV) || (phase == PH_ADRH) ||
                (phase == PH_ADRL) || (phase == PH_WDATA);
    byte_done = rx_phase && scl_fall && !ack_slot && (bitn == 4'd8);
    dev_hit   = (sr[7:5] == DEV_TYPE) && (sr[3:1] == chip_en) && !busy;
    wr_ok     = !wr_ctl && (!id_sel || (!locked && (!lock_arm || sr[LOCK_DATA_BIT])));
    unique case (phase)
      PH_DEV:           give_ack = dev_hit;
      PH_ADRH, PH_ADRL: give_ack = 1'b1;
      PH_WDATA:         give_ack = wr_ok;
      default:          give_ack = 1'b0;
    endcase
    st_we = byte_done && (phase == PH_WDATA) && wr_ok && !lock_arm;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase <= PH_IDLE; bitn <= '0; ack_slot <= 1'b0; acked <= 1'b0;
      mack <= 1'b0; sr <= '0; tx <= '0; hi_q <= '0; id_sel <= 1'b0;
      lock_arm <= 1'b0; lock_pend <= 1'b0; wrote <= 1'b0;
      ptr <= '0; sda_oe <= 1'b0;
    end else if (start_ev) begin
      phase <= PH_DEV; bitn <= '0; ack_slot <= 1'b0; sda_oe <= 1'b0;
    end else if (stop_ev) begin
      phase <= PH_IDLE; bitn <= '0; ack_slot <= 1'b0; sda_oe <= 1'b0;
      wrote <= 1'b0; lock_pend <= 1'b0;
    end else if (rx_phase) begin
      if (scl_rise && !ack_slot) begin
        sr   <= {sr[6:0], sda_s};
        bitn <= bitn + 4'd1;
      end
      if (byte_done) begin
        ack_slot <= 1'b1;
        sda_oe   <= give_ack;
        acked    <= give_ack;
        unique case (phase)
          PH_DEV:  if (give_ack) id_sel <= sr[4];
          PH_ADRH: hi_q <= sr;
          PH_ADRL: begin
            ptr      <= ADDR_W'({hi_q, sr});
            lock_arm <= id_sel && hi_q[LOCK_HI_BIT];
          end
          default: if (give_ack) begin
            if (lock_arm) lock_pend <= 1'b1;
            else begin
              ptr   <= page_inc;
              wrote <= 1'b1;
            end
          end
        endcase
      end else if (scl_fall && ack_slot) begin
        ack_slot <= 1'b0;
        bitn     <= '0;
        sda_oe   <= 1'b0;
        if (!acked) phase <= PH_IGNORE;
        else begin
          unique case (phase)
            PH_DEV: if (sr[0]) begin
              phase  <= PH_RDATA;
              tx     <= rdata;
              sda_oe <= !rdata[7];
              ptr    <= rd_inc;
            end else phase <= PH_ADRH;
            PH_ADRH: phase <= PH_ADRL;
            PH_ADRL: phase <= PH_WDATA;
            default: phase <= PH_WDATA;
          endcase
        end
      end
    end else if (phase == PH_RDATA) begin
      if (scl_rise) begin
        if (ack_slot) mack <= !sda_s;
        else bitn <= bitn + 4'd1;
      end
      if (scl_fall) begin
        if (ack_slot) begin
          ack_slot <= 1'b0;
          bitn     <= '0;
          if (mack) begin
            tx     <= rdata;
            sda_oe <= !rdata[7];
            ptr    <= rd_inc;
          end else begin
            phase  <= PH_IGNORE;
            sda_oe <= 1'b0;
          end
        end else if (bitn == 4'd8) begin
          ack_slot <= 1'b1;
          sda_oe   <= 1'b0;
        end else begin
          tx     <= {tx[6:0], 1'b0};
          sda_oe <= !tx[6];
        end
      end
    end
  end
endmodule

// File: rtl/i2c_eeprom_ctl_checker.sv
module i2c_eeprom_ctl_checker
  import eeprom_pkg::*;
(
  input logic   clk,
  input logic   rst_n,
  input logic   wr_ctl,
  input logic   sda_oe,
  input logic   stop_ev,
  input logic   busy,
  input logic   st_we,
  input logic   id_sel,
  input logic   locked,
  input phase_t phase
);
  AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    stop_ev |=> !sda_oe); // R11
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_IDLE) |-> !sda_oe); // R11
  AST_WC_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctl |-> !st_we); // R7
  AST_BUSY_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !st_we); // R8
  AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> locked); // R10
  AST_LOCKED_ID_RO: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && id_sel) |-> !st_we); // R10
endmodule

bind i2c_eeprom_ctl i2c_eeprom_ctl_checker u_chk (
  .clk(clk), .rst_n(rst_n), .wr_ctl(wr_ctl), .sda_oe(sda_oe),
  .stop_ev(stop_ev), .busy(busy), .st_we(st_we), .id_sel(id_sel),
  .locked(locked), .phase(phase)
);

// File: tb/tb_i2c_eeprom_ctl.sv
module tb_i2c_eeprom_ctl;
  localparam int CLK_NS = 10;
  localparam int Q      = 5;
  localparam int AW     = 8;
  localparam int PW     = 5;
  localparam int PROG   = 400;
  localparam int MASK   = (1 << AW) - 1;
  localparam int PMASK  = (1 << PW) - 1;
  localparam logic [2:0] CE = 3'b101;

  logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, m_low = 1'b0, wc = 1'b0;
  logic oe, sda_w;
  assign sda_w = !(m_low || oe);

  int n_chk = 0, n_fail = 0, last_polls = 0;
  logic [7:0] ref_mem [1<<AW];
  bit         ref_val [1<<AW];
  logic [7:0] ref_id  [1<<PW];
  bit ref_lock = 1'b0;
  int ref_ptr = 0;

  i2c_eeprom_ctl #(.ADDR_W(AW), .PAGE_W(PW), .PROG_CYCLES(PROG)) dut (
    .clk(clk), .rst_n(rst_n), .scl_in(scl), .sda_in(sda_w), .sda_oe(oe),
    .chip_en(CE), .wr_ctl(wc)
  );

  always #(CLK_NS/2) clk = ~clk;

  task automatic wait_q();
    repeat (Q) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] dev(input bit id, input bit rd);
    return {3'b101, id, CE, rd};
  endfunction

  function automatic int page_next(input int p);
    return (p & ~PMASK) | ((p + 1) & PMASK);
  endfunction

  task automatic bus_bit(input bit b, output bit s);
    m_low = !b; wait_q();
    scl = 1'b1; wait_q();
    s = sda_w;  wait_q();
    scl = 1'b0; wait_q();
  endtask

  task automatic i2c_start();
    m_low = 1'b0; wait_q(); scl = 1'b1; wait_q();
    m_low = 1'b1; wait_q(); scl = 1'b0; wait_q();
  endtask

  task automatic i2c_stop();
    m_low = 1'b1; wait_q(); scl = 1'b1; wait_q();
    m_low = 1'b0; wait_q(); wait_q();
  endtask

  task automatic wbyte(input logic [7:0] b, output bit ack);
    bit s;
    for (int i = 7; i >= 0; i--) bus_bit(b[i], s);
    bus_bit(1'b1, s);
    ack = !s;
  endtask

  task automatic rbyte(input bit give_ack, output logic [7:0] b);
    bit s;
    for (int i = 7; i >= 0; i--) begin
      bus_bit(1'b1, s);
      b[i] = s;
    end
    bus_bit(!give_ack, s);
  endtask

  task automatic wait_ready();
    bit ack;
    last_polls = 0;
    do begin
      i2c_start(); wbyte(dev(1'b0, 1'b0), ack); i2c_stop();
      last_polls++;
    end while (!ack && last_polls < 40);
    check(ack, "R8 select acked after programming", ack, 1);
  endtask

  task automatic do_write(input bit id, input logic [15:0] a, input int n,
                          input bit wcv, input string req, input bit no_wait);
    bit ack, ok_exp, any;
    logic [7:0] d;
    wc = wcv; any = 1'b0;
    i2c_start();
    wbyte(dev(id, 1'b0), ack); check(ack, "R1 write select ack", ack, 1);
    wbyte(a[15:8], ack);       check(ack, "R2 high address ack", ack, 1);
    wbyte(a[7:0], ack);        check(ack, "R2 low address ack", ack, 1);
    ref_ptr = a & MASK;
    ok_exp = !wcv && !(id && ref_lock);
    for (int k = 0; k < n; k++) begin
      d = 8'($urandom);
      wbyte(d, ack);
      check(ack == ok_exp, req, ack, ok_exp);
      if (ok_exp) begin
        if (id) ref_id[ref_ptr & PMASK] = d;
        else begin
          ref_mem[ref_ptr] = d;
          ref_val[ref_ptr] = 1'b1;
        end
        ref_ptr = page_next(ref_ptr);
        any = 1'b1;
      end
    end
    i2c_stop();
    wc = 1'b0;
    if (any && !no_wait) wait_ready();
  endtask

  task automatic do_read(input bit id, input bit set_addr, input logic [15:0] a,
                         input int n, input string req);
    bit ack;
    logic [7:0] b, e;
    if (set_addr) begin
      i2c_start();
      wbyte(dev(id, 1'b0), ack); check(ack, "R4 dummy write select ack", ack, 1);
      wbyte(a[15:8], ack);       check(ack, "R4 high address ack", ack, 1);
      wbyte(a[7:0], ack);        check(ack, "R4 low address ack", ack, 1);
      ref_ptr = a & MASK;
    end
    i2c_start();
    wbyte(dev(id, 1'b1), ack); check(ack, "R1 read select ack", ack, 1);
    for (int k = 0; k < n; k++) begin
      rbyte(k < n - 1, b);
      if (id) begin
        e = ref_id[ref_ptr & PMASK];
        check(b == e, req, b, e);
        ref_ptr = page_next(ref_ptr);
      end else begin
        e = ref_mem[ref_ptr];
        if (ref_val[ref_ptr]) check(b == e, req, b, e);
        ref_ptr = (ref_ptr + 1) & MASK;
      end
    end
    i2c_stop();
    check(oe == 1'b0, "R6 bus released after master nack", oe, 0);
  endtask

  task automatic do_lock(input bit exp_ack);
    bit ack;
    i2c_start();
    wbyte(dev(1'b1, 1'b0), ack);
    wbyte(8'h04, ack);
    wbyte(8'h00, ack);
    ref_ptr = 0;
    wbyte(8'h02, ack);
    check(ack == exp_ack, "R10 lock command ack", ack, exp_ack);
    i2c_stop();
    if (exp_ack) begin
      ref_lock = 1'b1;
      wait_ready();
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog all requirements actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    bit ack;
    int kind, n;
    logic [15:0] a;
    void'($urandom(32'd2024));
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check(oe == 1'b0 && sda_w == 1'b1, "R11 reset releases SDA", oe, 0);

    i2c_start(); wbyte({4'b1010, 3'b010, 1'b0}, ack); i2c_stop();
    check(!ack, "R1 wrong chip enable refused", ack, 0);
    i2c_start(); wbyte({4'b1110, CE, 1'b0}, ack); i2c_stop();
    check(!ack, "R1 wrong device type refused", ack, 0);
    check(oe == 1'b0, "R11 SDA released after stop", oe, 0);

    do_write(1'b1, 16'h0000, 32, 1'b0, "R9 id page write ack", 1'b0);
    do_read(1'b1, 1'b1, 16'h0000, 32, "R9 id page readback");

    do_write(1'b0, 16'h1F05, 1, 1'b0, "R2 byte write ack", 1'b0);
    do_read(1'b0, 1'b1, 16'h0005, 1, "R2 byte write readback");
    do_read(1'b0, 1'b1, 16'h0E05, 1, "R4 random read ignores upper bits");

    do_write(1'b0, 16'h0010, 2, 1'b0, "R2 write before busy", 1'b1);
    i2c_start(); wbyte(dev(1'b0, 1'b0), ack); i2c_stop();
    check(!ack, "R8 select refused while programming", ack, 0);
    wait_ready();

    do_write(1'b0, 16'h001C, 8, 1'b0, "R3 page write ack", 1'b0);
    do_read(1'b0, 1'b1, 16'h0000, 32, "R3 page wrap readback");

    do_write(1'b0, 16'h0060, 3, 1'b0, "R5 setup write", 1'b0);
    do_read(1'b0, 1'b0, 16'h0000, 1, "R5 current read after write");
    do_read(1'b0, 1'b1, 16'h0060, 1, "R4 random read");
    do_read(1'b0, 1'b0, 16'h0000, 2, "R5 current read after read");

    do_write(1'b0, 16'h00FE, 2, 1'b0, "R6 setup write", 1'b0);
    do_read(1'b0, 1'b1, 16'h00FE, 4, "R6 sequential rollover");
    do_read(1'b0, 1'b0, 16'h0000, 1, "R5 current read after rollover");

    do_write(1'b0, 16'h0005, 3, 1'b1, "R7 write control refuses data", 1'b0);
    do_read(1'b0, 1'b1, 16'h0005, 1, "R7 array unchanged");
    do_write(1'b1, 16'h0003, 1, 1'b1, "R7 id page refused under write control", 1'b0);
    do_read(1'b1, 1'b1, 16'h0000, 4, "R7 id page unchanged");

    for (int t = 0; t < 24; t++) begin
      kind = $urandom % 4;
      case (kind)
        0: begin
          a = {3'b000, 5'($urandom), 8'($urandom)};
          n = 1 + $urandom % 10;
          do_write(1'b0, a, n, ($urandom % 4) == 0, "R3 random page write", 1'b0);
        end
        1: begin
          a = {8'h00, 3'b000, 5'($urandom)};
          n = 1 + $urandom % 6;
          do_write(1'b1, a, n, 1'b0, "R9 random id write", 1'b0);
        end
        2: begin
          a = {8'($urandom), 8'($urandom)};
          n = 1 + $urandom % 8;
          do_read(1'b0, 1'b1, a, n, "R6 random sequential read");
        end
        default: begin
          n = 1 + $urandom % 4;
          do_read(1'($urandom), 1'b0, 16'h0000, n, "R5 random current read");
        end
      endcase
    end

    do_lock(1'b1);
    do_write(1'b1, 16'h0002, 2, 1'b0, "R10 locked id page refuses data", 1'b0);
    do_read(1'b1, 1'b1, 16'h0000, 32, "R10 id page unchanged after lock");
    do_lock(1'b0);
    do_write(1'b0, 16'h0030, 1, 1'b0, "R10 array writable after lock", 1'b0);
    do_read(1'b0, 1'b1, 16'h0030, 1, "R10 array readback after lock");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule